// File: doc/BRIEF.md
# Privileged Register Access Gate

This block stands in front of a reserved group of implementation-specific system registers. For every instruction that reaches it, it decides one of three outcomes: the access is allowed, it traps to a higher privilege level, or it is undefined. The decision uses the current privilege level (0 to 3), the decoded instruction fields, the access kind and a set of control bits. These bits are trap controls for levels 1 and 2 and for the hypervisor, a host-mode flag, a guest-routing bit, and separate enables for 128-bit access. The enables are kept per level, for the hypervisor extension and for level 3.

When an access is allowed, the block serves it from a bank of 128-bit registers. The bank also accepts 64-bit accesses, which reach only the low half. On a trap the block reports the target level and an exception class code. The code tells a 64-bit access from a 128-bit one. Every response comes one clock after its request. Exception entry and pipeline flushing happen elsewhere.

Top module: `impreg_access_gate`

## Requirements
- R1: A request is in the reserved space only when `op0` is 2'b11, `crn[3]` is 1 and `crn[1:0]` is 2'b11 (`crn[2]`, `op1` and `crm` are free). An in-space request raises `respValid` on the next clock. An out-of-space request gives no response and leaves the bank unchanged.
- R2: `result` encodes 2'b00 allow, 2'b01 trap, 2'b10 undefined. `trapLevel` and `excClass` are zero unless `result` is trap, and all outputs are zero after reset.
- R3: Accesses at level 3 are always allowed.
- R4: At level 2 a 64-bit access is always allowed. A 128-bit access at level 2 can fail only through the level-3 enable: when `lvl3Present` is set and `wide3En` is clear, it is undefined if `undefPrio` or `undefSel` is set, and otherwise it traps to level 3.
- R5: At level 0 outside host mode, `trapCtlL1` traps the access. The target is level 2 when `lvl2Enabled` and `guestRoute` are both set, and level 1 otherwise. At level 0 in host mode, `trapCtlL2` traps the access to level 2.
- R6: At level 1, `lvl2Enabled` together with `trapCtlHyp` traps the access to level 2.
- R7: `excClass` is 6'h18 for a trapped 64-bit access and 6'h14 for a trapped 128-bit access.
- R8: For 128-bit accesses below level 3 the checks take priority in this order: (1) the early undefined check (`lvl3Present`, `undefPrio` set, `wide3En` clear); (2) the trap-control bits; (3) the per-level and hypervisor 128-bit enables; (4) the level-3 enable.
- R9: A 128-bit access traps when the enable for its own context is missing:
  - at level 0 outside host mode, when `ext1On` and `wide1En` are not both set, to the same target as in R5;
  - at level 0 in host mode, when `ext2On` and `wide2En` are not both set, to level 2;
  - at level 0 outside host mode or at level 1, when `lvl2Enabled` is set and `extHOn` and `wideHEn` are not both set, to level 2.
- R10: At levels 0 to 2, a 128-bit access that passes every earlier check but finds `lvl3Present` set and `wide3En` clear is undefined if `undefSel` is set, and otherwise traps to level 3.
- R11: The bank holds 8 entries selected by `op2[2:0]` and resets to zero. An allowed 128-bit write stores `wDataLo` into bits [63:0] and `wDataHi` into bits [127:64]. An allowed 128-bit read returns bits [63:0] on `rDataLo` and bits [127:64] on `rDataHi` on the next clock.
- R12: A 64-bit write changes only bits [63:0] of the entry. A 64-bit read returns bits [63:0] on `rDataLo` with `rDataHi` at zero.
- R13: A write whose result is trap or undefined leaves the bank unchanged. The read data of any response that is not allowed is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| accKind | input | 2 | 0 read64, 1 write64, 2 read128, 3 write128 |
| curLevel | input | 2 | Current privilege level |
| op0 | input | 2 | Instruction field op0 |
| op1 | input | 3 | Instruction field op1 (free) |
| crn | input | 4 | Instruction field CRn |
| crm | input | 4 | Instruction field CRm (free) |
| op2 | input | 3 | Instruction field op2, selects the entry |
| wDataLo | input | 64 | Write data, low half |
| wDataHi | input | 64 | Write data, high half |
| hostMode | input | 1 | Level 0 is running under a host at level 2 |
| lvl2Enabled | input | 1 | Level 2 is enabled |
| lvl3Present | input | 1 | Level 3 is implemented |
| guestRoute | input | 1 | Route level-0 traps to level 2 |
| trapCtlL1 | input | 1 | Level-1 trap control for level 0 |
| trapCtlL2 | input | 1 | Level-2 trap control for host-mode level 0 |
| trapCtlHyp | input | 1 | Hypervisor trap control |
| ext1On | input | 1 | Level-1 extension control register enabled |
| wide1En | input | 1 | Level-1 128-bit enable |
| ext2On | input | 1 | Level-2 extension control register enabled |
| wide2En | input | 1 | Level-2 128-bit enable |
| extHOn | input | 1 | Hypervisor extension register enabled |
| wideHEn | input | 1 | Hypervisor 128-bit enable |
| wide3En | input | 1 | Level-3 128-bit enable |
| undefPrio | input | 1 | Early undefined check active |
| undefSel | input | 1 | Final level-3 check gives undefined instead of trap |
| respValid | output | 1 | Response valid |
| result | output | 2 | Outcome code |
| trapLevel | output | 2 | Trap target level |
| excClass | output | 6 | Exception class code |
| rDataLo | output | 64 | Read data, low half |
| rDataHi | output | 64 | Read data, high half |

## Verification
The bench covers the places where the priority chain can go wrong. An early undefined check that is evaluated too late turns into a trap. A missing hypervisor enable check lets a level-1 128-bit access through. A trap that ignores `guestRoute` lands at level 1 instead of level 2. A 128-bit trap that uses the 64-bit class code reports 6'h18. The bank is also probed through its own ports in four ways. A 64-bit write that leaks into the high half corrupts a following 128-bit read. A trapped or out-of-space write that still commits shows up when the entry is read back. A 64-bit read that forwards the high half shows nonzero `rDataHi`. Swapped halves show at once.

// File: rtl/impreg_pkg.sv
package impreg_pkg;

  typedef enum logic [1:0] {
    RES_ALLOW = 2'b00,
    RES_TRAP  = 2'b01,
    RES_UNDEF = 2'b10
  } result_e;

  localparam logic [5:0] EC_NARROW = 6'h18;
  localparam logic [5:0] EC_WIDE   = 6'h14;

  // control inputs gathered into one bundle
  typedef struct packed {
    logic hostMode;
    logic lvl2Enabled;
    logic lvl3Present;
    logic guestRoute;
    logic trapCtlL1;
    logic trapCtlL2;
    logic trapCtlHyp;
    logic ext1On;
    logic wide1En;
    logic ext2On;
    logic wide2En;
    logic extHOn;
    logic wideHEn;
    logic wide3En;
    logic undefPrio;
    logic undefSel;
  } ctl_t;

  // strobes from control to the register bank
  typedef struct packed {
    logic rdLo;
    logic rdHi;
    logic wrLo;
    logic wrHi;
  } bankStb_t;

endpackage

// File: rtl/impreg_ctrl.sv
module impreg_ctrl
  import impreg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  logic       inSpace,
  input  logic [1:0] accKind,
  input  logic [1:0] curLevel,
  input  ctl_t       ctl,
  output bankStb_t   stb,
  output logic       respValid,
  output logic [1:0] result,
  output logic [1:0] trapLevel,
  output logic [5:0] excClass
);

  logic    wide, isWrite, earlyUndef, lateFail, hypWideOff, go, okGo;
  logic [1:0] l0Route, dLvl;
  result_e dRes;

  assign wide       = accKind[1];
  assign isWrite    = accKind[0];
  assign earlyUndef = wide && ctl.lvl3Present && ctl.undefPrio && !ctl.wide3En;
  assign lateFail   = wide && ctl.lvl3Present && !ctl.wide3En;
  assign hypWideOff = ctl.lvl2Enabled && !(ctl.extHOn && ctl.wideHEn);
  assign l0Route    = (ctl.lvl2Enabled && ctl.guestRoute) ? 2'd2 : 2'd1;

  // priority chain, first match wins
  always_comb begin
    dRes = RES_ALLOW;
    dLvl = 2'd0;
    unique case (curLevel)
      2'd0: begin
        if (earlyUndef) dRes = RES_UNDEF;
        else if (!ctl.hostMode && ctl.trapCtlL1) begin dRes = RES_TRAP; dLvl = l0Route; end
        else if (ctl.hostMode && ctl.trapCtlL2) begin dRes = RES_TRAP; dLvl = 2'd2; end
        else if (wide && !ctl.hostMode && !(ctl.ext1On && ctl.wide1En)) begin
          dRes = RES_TRAP; dLvl = l0Route;
        end
        else if (wide && ctl.hostMode && !(ctl.ext2On && ctl.wide2En)) begin
          dRes = RES_TRAP; dLvl = 2'd2;
        end
        else if (wide && !ctl.hostMode && hypWideOff) begin dRes = RES_TRAP; dLvl = 2'd2; end
        else if (lateFail) begin
          if (ctl.undefSel) dRes = RES_UNDEF;
          else begin dRes = RES_TRAP; dLvl = 2'd3; end
        end
      end
      2'd1: begin
        if (earlyUndef) dRes = RES_UNDEF;
        else if (ctl.lvl2Enabled && ctl.trapCtlHyp) begin dRes = RES_TRAP; dLvl = 2'd2; end
        else if (wide && hypWideOff) begin dRes = RES_TRAP; dLvl = 2'd2; end
        else if (lateFail) begin
          if (ctl.undefSel) dRes = RES_UNDEF;
          else begin dRes = RES_TRAP; dLvl = 2'd3; end
        end
      end
      2'd2: begin
        if (earlyUndef) dRes = RES_UNDEF;
        else if (lateFail) begin
          if (ctl.undefSel) dRes = RES_UNDEF;
          else begin dRes = RES_TRAP; dLvl = 2'd3; end
        end
      end
      default: dRes = RES_ALLOW;
    endcase
  end

  assign go   = reqValid && inSpace;
  assign okGo = go && (dRes == RES_ALLOW);

  always_comb begin
    stb.rdLo = okGo && !isWrite;
    stb.rdHi = okGo && !isWrite && wide;
    stb.wrLo = okGo && isWrite;
    stb.wrHi = okGo && isWrite && wide;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      respValid <= 1'b0;
      result    <= RES_ALLOW;
      trapLevel <= 2'd0;
      excClass  <= 6'd0;
    end else begin
      respValid <= go;
      result    <= go ? dRes : RES_ALLOW;
      trapLevel <= (go && dRes == RES_TRAP) ? dLvl : 2'd0;
      excClass  <= (go && dRes == RES_TRAP) ? (wide ? EC_WIDE : EC_NARROW) : 6'd0;
    end
  end

endmodule

// File: rtl/impreg_bank.sv
module impreg_bank
  import impreg_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int HALF_W = 64,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bankStb_t          stb,
  input  logic [IDX_W-1:0]  idx,
  input  logic [HALF_W-1:0] wLo,
  input  logic [HALF_W-1:0] wHi,
  output logic [HALF_W-1:0] rLo,
  output logic [HALF_W-1:0] rHi
);

  logic [HALF_W-1:0] loView [DEPTH];
  logic [HALF_W-1:0] hiView [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : gEntry
    logic [HALF_W-1:0] loQ, hiQ;
    logic              hit;
    assign hit = (idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        loQ <= '0;
        hiQ <= '0;
      end else begin
        if (stb.wrLo && hit) loQ <= wLo;
        if (stb.wrHi && hit) hiQ <= wHi;
      end
    end
    assign loView[g] = loQ;
    assign hiView[g] = hiQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rLo <= '0;
      rHi <= '0;
    end else begin
      rLo <= stb.rdLo ? loView[idx] : '0;
      rHi <= stb.rdHi ? hiView[idx] : '0;
    end
  end

endmodule

// File: rtl/impreg_access_gate.sv
module impreg_access_gate
  import impreg_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int HALF_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [1:0]        accKind,
  input  logic [1:0]        curLevel,
  input  logic [1:0]        op0,
  input  logic [2:0]        op1,
  input  logic [3:0]        crn,
  input  logic [3:0]        crm,
  input  logic [2:0]        op2,
  input  logic [HALF_W-1:0] wDataLo,
  input  logic [HALF_W-1:0] wDataHi,
  input  logic              hostMode,
  input  logic              lvl2Enabled,
  input  logic              lvl3Present,
  input  logic              guestRoute,
  input  logic              trapCtlL1,
  input  logic              trapCtlL2,
  input  logic              trapCtlHyp,
  input  logic              ext1On,
  input  logic              wide1En,
  input  logic              ext2On,
  input  logic              wide2En,
  input  logic              extHOn,
  input  logic              wideHEn,
  input  logic              wide3En,
  input  logic              undefPrio,
  input  logic              undefSel,
  output logic              respValid,
  output logic [1:0]        result,
  output logic [1:0]        trapLevel,
  output logic [5:0]        excClass,
  output logic [HALF_W-1:0] rDataLo,
  output logic [HALF_W-1:0] rDataHi
);

  localparam int IDX_W = $clog2(DEPTH);

  ctl_t     ctl;
  bankStb_t stb;
  logic     inSpace;
  logic     unusedSel;

  assign ctl = '{hostMode, lvl2Enabled, lvl3Present, guestRoute, trapCtlL1, trapCtlL2,
                 trapCtlHyp, ext1On, wide1En, ext2On, wide2En, extHOn, wideHEn,
                 wide3En, undefPrio, undefSel};

  // reserved space: op0 = 3, crn = 1x11
  assign inSpace   = (op0 == 2'b11) && crn[3] && (crn[1:0] == 2'b11);
  assign unusedSel = ^{op1, crm, crn[2]};

  impreg_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .inSpace(inSpace),
    .accKind(accKind), .curLevel(curLevel), .ctl(ctl), .stb(stb),
    .respValid(respValid), .result(result), .trapLevel(trapLevel), .excClass(excClass)
  );

  impreg_bank #(.DEPTH(DEPTH), .HALF_W(HALF_W), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .stb(stb), .idx(op2[IDX_W-1:0]),
    .wLo(wDataLo), .wHi(wDataHi), .rLo(rDataLo), .rHi(rDataHi)
  );

endmodule

// File: rtl/impreg_access_gate_chk.sv
module impreg_access_gate_chk #(
  parameter int HALF_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqValid,
  input logic [1:0]        accKind,
  input logic [1:0]        curLevel,
  input logic [1:0]        op0,
  input logic [3:0]        crn,
  input logic              lvl2Enabled,
  input logic              lvl3Present,
  input logic              trapCtlHyp,
  input logic              undefPrio,
  input logic              wide3En,
  input logic              respValid,
  input logic [1:0]        result,
  input logic [1:0]        trapLevel,
  input logic [5:0]        excClass,
  input logic [HALF_W-1:0] rDataLo,
  input logic [HALF_W-1:0] rDataHi
);

  logic reqIn;
  assign reqIn = reqValid && op0 == 2'b11 && crn[3] && crn[1:0] == 2'b11;

  assert_resp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reqIn |=> respValid);

  assert_no_resp_outside_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !reqIn |=> !respValid);

  assert_trap_fields_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (result != 2'b01) |-> (trapLevel == 2'd0 && excClass == 6'd0));

  assert_top_level_allows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reqIn && curLevel == 2'd3) |=> (result == 2'b00));

  assert_narrow_l2_allows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reqIn && curLevel == 2'd2 && !accKind[1]) |=> (result == 2'b00));

  assert_hyp_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reqIn && curLevel == 2'd1 && lvl2Enabled && trapCtlHyp &&
     !(accKind[1] && lvl3Present && undefPrio && !wide3En))
    |=> (result == 2'b01 && trapLevel == 2'd2));

  assert_class_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (respValid && result == 2'b01) |->
    (excClass == ($past(accKind[1]) ? 6'h14 : 6'h18)));

  assert_narrow_read_hi_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (reqIn && accKind == 2'b00) |=> (rDataHi == '0));

  assert_denied_no_data_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (result != 2'b00) |-> (rDataLo == '0 && rDataHi == '0));

endmodule

bind impreg_access_gate impreg_access_gate_chk #(.HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .accKind(accKind),
  .curLevel(curLevel), .op0(op0), .crn(crn), .lvl2Enabled(lvl2Enabled),
  .lvl3Present(lvl3Present), .trapCtlHyp(trapCtlHyp), .undefPrio(undefPrio),
  .wide3En(wide3En), .respValid(respValid), .result(result),
  .trapLevel(trapLevel), .excClass(excClass), .rDataLo(rDataLo), .rDataHi(rDataHi)
);

// File: tb/test_impreg_access_gate.sv
module test_impreg_access_gate;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] accKind = '0, curLevel = '0, op0 = '0;
  logic [2:0] op1 = '0, op2 = '0;
  logic [3:0] crn = '0, crm = '0;
  logic [63:0] wDataLo = '0, wDataHi = '0;
  logic hostMode = 0, lvl2Enabled = 0, lvl3Present = 0, guestRoute = 0;
  logic trapCtlL1 = 0, trapCtlL2 = 0, trapCtlHyp = 0;
  logic ext1On = 0, wide1En = 0, ext2On = 0, wide2En = 0, extHOn = 0, wideHEn = 0;
  logic wide3En = 0, undefPrio = 0, undefSel = 0;
  logic respValid;
  logic [1:0] result, trapLevel;
  logic [5:0] excClass;
  logic [63:0] rDataLo, rDataHi;

  int checks = 0;
  int errors = 0;
  logic [63:0] mLo [8];
  logic [63:0] mHi [8];

  always #4 clk = ~clk;

  impreg_access_gate i_impreg_access_gate (.*);

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // reference: returns {result, level}
  function automatic logic [3:0] refDecide();
    bit w = accKind[1];
    bit l3off = lvl3Present && !wide3En;
    logic [1:0] route = (lvl2Enabled && guestRoute) ? 2'd2 : 2'd1;
    if (curLevel == 2'd3) return 4'b0000;
    if (w && l3off && undefPrio) return 4'b1000;
    if (curLevel == 2'd0) begin
      if (hostMode) begin
        if (trapCtlL2) return 4'b0110;
        if (w && !(ext2On && wide2En)) return 4'b0110;
      end else begin
        if (trapCtlL1) return {2'b01, route};
        if (w && !(ext1On && wide1En)) return {2'b01, route};
        if (w && lvl2Enabled && !(extHOn && wideHEn)) return 4'b0110;
      end
    end
    if (curLevel == 2'd1) begin
      if (lvl2Enabled && trapCtlHyp) return 4'b0110;
      if (w && lvl2Enabled && !(extHOn && wideHEn)) return 4'b0110;
    end
    if (w && l3off) return undefSel ? 4'b1000 : 4'b0111;
    return 4'b0000;
  endfunction

  // apply current inputs for one clock and compare against the model
  task automatic step(input string tag);
    logic ev;
    logic [3:0] d;
    logic [1:0] er, el;
    logic [5:0] ec;
    logic [63:0] eLo, eHi;
    int k;
    ev = reqValid && op0 == 2'b11 && crn[3] && crn[1:0] == 2'b11;
    er = 0; el = 0; ec = 0; eLo = 0; eHi = 0; k = int'(op2);
    if (ev) begin
      d = refDecide();
      er = d[3:2];
      if (er == 2'b01) begin
        el = d[1:0];
        ec = accKind[1] ? 6'h14 : 6'h18;
      end
      if (er == 2'b00) begin
        case (accKind)
          2'd0: eLo = mLo[k];
          2'd1: mLo[k] = wDataLo;
          2'd2: begin eLo = mLo[k]; eHi = mHi[k]; end
          default: begin mLo[k] = wDataLo; mHi[k] = wDataHi; end
        endcase
      end
    end
    @(negedge clk);
    chk(tag, "respValid", 64'(respValid), 64'(ev));
    chk(tag, "result", 64'(result), 64'(er));
    chk(tag, "trapLevel", 64'(trapLevel), 64'(el));
    chk(tag, "excClass", 64'(excClass), 64'(ec));
    chk(tag, "rDataLo", rDataLo, eLo);
    chk(tag, "rDataHi", rDataHi, eHi);
  endtask

  task automatic permissive();
    hostMode = 0; lvl2Enabled = 0; lvl3Present = 0; guestRoute = 0;
    trapCtlL1 = 0; trapCtlL2 = 0; trapCtlHyp = 0;
    ext1On = 1; wide1En = 1; ext2On = 1; wide2En = 1; extHOn = 1; wideHEn = 1;
    wide3En = 1; undefPrio = 0; undefSel = 0;
  endtask

  task automatic req(input logic [1:0] kind, input logic [1:0] lvl, input logic [2:0] idx,
                     input logic [63:0] lo, input logic [63:0] hi);
    reqValid = 1; accKind = kind; curLevel = lvl; op0 = 2'b11; crn = 4'b1011;
    op1 = 3'(idx + 3'd1); crm = {1'b0, idx}; op2 = idx; wDataLo = lo; wDataHi = hi;
  endtask

  task automatic idle(input string tag);
    reqValid = 0;
    step(tag);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mLo[i] = '0; mHi[i] = '0; end
    permissive();
    @(negedge clk);
    chk("R2 reset", "respValid", 64'(respValid), 64'd0);
    chk("R2 reset", "rDataLo", rDataLo, 64'd0);
    rst_n = 1;
    // R11 reset contents
    for (int i = 0; i < 8; i++) begin req(2'd2, 2'd3, 3'(i), 0, 0); step("R11 reset zero"); end
    // R11 wide write and read back
    req(2'd3, 2'd3, 3'd5, 64'hAAAA_0000_1111_2222, 64'hBBBB_3333_4444_5555); step("R11 wr128");
    req(2'd2, 2'd3, 3'd5, 0, 0); step("R11 rd128");
    // R12 narrow write keeps high half, narrow read zero high
    req(2'd1, 2'd3, 3'd5, 64'hC0DE_C0DE_C0DE_C0DE, 64'hFFFF); step("R12 wr64");
    req(2'd2, 2'd3, 3'd5, 0, 0); step("R12 rd128 after wr64");
    req(2'd0, 2'd3, 3'd5, 0, 0); step("R12 rd64");
    // R1 out-of-space requests
    req(2'd3, 2'd3, 3'd5, 1, 2); op0 = 2'b10; step("R1 op0 mismatch");
    req(2'd3, 2'd3, 3'd5, 1, 2); crn = 4'b1001; step("R1 crn mismatch");
    req(2'd3, 2'd3, 3'd5, 1, 2); crn = 4'b0011; step("R1 crn msb clear");
    req(2'd2, 2'd3, 3'd5, 0, 0); step("R1 unchanged after outside");
    req(2'd3, 2'd3, 3'd6, 64'h66, 64'h77); crn = 4'b1111; step("R1 free crn bit");
    idle("R1 idle");
    // R3 level 3 ignores everything
    trapCtlL1 = 1; trapCtlL2 = 1; trapCtlHyp = 1; lvl2Enabled = 1; lvl3Present = 1;
    wide3En = 0; undefPrio = 1; undefSel = 1;
    req(2'd3, 2'd3, 3'd1, 64'h11, 64'h22); step("R3 level3 allow");
    // R4 level 2
    req(2'd1, 2'd2, 3'd1, 64'h33, 0); step("R4 l2 narrow allow");
    req(2'd2, 2'd2, 3'd1, 0, 0); step("R4 l2 wide early undef");
    undefPrio = 0; undefSel = 0; req(2'd2, 2'd2, 3'd1, 0, 0); step("R4 l2 trap to 3");
    undefSel = 1; req(2'd2, 2'd2, 3'd1, 0, 0); step("R4 l2 undef");
    wide3En = 1; req(2'd2, 2'd2, 3'd1, 0, 0); step("R4 l2 wide allow");
    // R5 level-0 trap controls
    permissive(); trapCtlL1 = 1;
    req(2'd0, 2'd0, 3'd2, 0, 0); step("R5 l0 trap to 1");
    lvl2Enabled = 1; guestRoute = 1; req(2'd0, 2'd0, 3'd2, 0, 0); step("R5 l0 guest to 2");
    guestRoute = 1; lvl2Enabled = 0; req(2'd2, 2'd0, 3'd2, 0, 0); step("R5 R7 guest w/o l2");
    permissive(); hostMode = 1; trapCtlL2 = 1; trapCtlL1 = 1;
    req(2'd1, 2'd0, 3'd2, 5, 0); step("R5 host trap to 2");
    // R13 denied write leaves entry, read back at level 3
    req(2'd3, 2'd0, 3'd2, 64'hDEAD, 64'hBEEF); step("R13 denied wr128");
    req(2'd2, 2'd3, 3'd2, 0, 0); step("R13 entry unchanged");
    // R6 level 1
    permissive(); lvl2Enabled = 1; trapCtlHyp = 1;
    req(2'd0, 2'd1, 3'd3, 0, 0); step("R6 R7 l1 hyp narrow");
    req(2'd3, 2'd1, 3'd3, 9, 9); step("R6 R7 l1 hyp wide");
    // R8 priority
    permissive(); trapCtlL1 = 1; lvl3Present = 1; wide3En = 0; undefPrio = 1;
    req(2'd2, 2'd0, 3'd4, 0, 0); step("R8 early undef beats trap bit");
    undefPrio = 0; wide3En = 1; wide1En = 0;
    req(2'd2, 2'd0, 3'd4, 0, 0); step("R8 trap bit before enable");
    trapCtlL1 = 0; wide3En = 0; req(2'd2, 2'd0, 3'd4, 0, 0); step("R8 enable before level3");
    // R9 per-level enables
    permissive(); ext1On = 0; lvl2Enabled = 1; guestRoute = 1;
    req(2'd3, 2'd0, 3'd4, 1, 1); step("R9 ext1 off guest");
    permissive(); hostMode = 1; wide2En = 0; req(2'd2, 2'd0, 3'd4, 0, 0); step("R9 host wide2 off");
    permissive(); lvl2Enabled = 1; wideHEn = 0; req(2'd2, 2'd0, 3'd4, 0, 0); step("R9 l0 hyp enable off");
    permissive(); lvl2Enabled = 1; extHOn = 0; req(2'd2, 2'd1, 3'd4, 0, 0); step("R9 l1 hyp ext off");
    hostMode = 1; req(2'd2, 2'd0, 3'd4, 0, 0); step("R9 host skips hyp enable");
    // R10 final level-3 enable
    permissive(); lvl3Present = 1; wide3En = 0;
    req(2'd2, 2'd0, 3'd4, 0, 0); step("R10 l0 trap to 3");
    undefSel = 1; req(2'd2, 2'd1, 3'd4, 0, 0); step("R10 l1 undef");
    lvl3Present = 0; req(2'd2, 2'd1, 3'd4, 0, 0); step("R10 no level3 allow");
    // random sweep against the model
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r = $urandom;
      logic [31:0] s = $urandom;
      reqValid = r[0] | r[1];
      accKind = r[3:2]; curLevel = r[5:4];
      op0 = r[6] ? 2'b11 : r[8:7];
      crn = r[9] ? {1'b1, r[10], 2'b11} : r[14:11];
      op1 = r[17:15]; crm = r[21:18]; op2 = r[24:22];
      wDataLo = {s, r}; wDataHi = {r, s};
      {hostMode, lvl2Enabled, lvl3Present, guestRoute} = s[3:0];
      trapCtlL1 = s[4] & s[5]; trapCtlL2 = s[6] & s[7]; trapCtlHyp = s[8] & s[9];
      ext1On = s[10] | s[11]; wide1En = s[12] | s[13]; ext2On = s[14] | s[15];
      wide2En = s[16] | s[17]; extHOn = s[18] | s[19]; wideHEn = s[20] | s[21];
      wide3En = s[22] | s[23]; undefPrio = s[24]; undefSel = s[25];
      step("R2 random");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule